// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block gathers 64 interrupt request lines and presents them to a processor through a small register space, reached by a simple read/write bus that accepts single-byte and full-word accesses. Every source owns one control byte. That byte enables or disables the source, selects level-high, rising-edge or falling-edge triggering, and routes the source to one of eight destinations: the normal interrupt line, the fast interrupt line, or one of six auxiliary lines.

Inputs pass through a two-stage synchroniser. Edge events are then caught in sticky latches. Software clears a latch by writing a one to its status bit. For level sources the status bit simply mirrors the synchronised input.

The normal and fast paths each have a number register that names the winning pending source. Each path also has a priority register. That register selects fixed priority, where the lowest number wins, or rotating priority, where the search begins just after a stored pointer. In rotating mode the pointer moves to the winner whenever software reads the number register. With nothing pending, the number register shows 63. Software tells this idle value apart from a real request on source 63 by looking at the top bit of the second status word.

Top module: `vic_rotprio`

## Requirements
- R1: After reset every control byte reads 0, all outputs are low, both number registers read 63 and both priority registers read 0 (fixed priority).
- R2: Bit 3 of the control byte of source n (byte address 0x40+n) enables it; a disabled source drives no output and is never reported as a winner, although its status bit still updates.
- R3: With control bits 6 and 5 both zero the source is level-sensitive, active high: its status bit follows the synchronised input and no event is stored.
- R4: Control bit 5 latches a rising edge and control bit 6 latches a falling edge; the latched bit stays set after the input returns to its idle level.
- R5: Writing 1 to a status bit of an edge source clears its latch, writing 0 leaves it, and writes have no effect on level sources.
- R6: Control bits 2:0 select the destination: 0 the normal output, 1 the fast output, 2 to 7 auxiliary outputs 0 to 5; each output is the OR of the enabled pending sources routed to it.
- R7: The status word at 0x80 holds sources 0 to 31 and the word at 0x84 holds sources 32 to 63, source n on bit n mod 32.
- R8: Reads at 0x00 (normal) and 0x04 (fast) return the winning source number in bits 5:0, or 63 when nothing on that path is pending; bit 31 of the word at 0x84 separates a real request on source 63 from the idle value.
- R9: In fixed priority, the lowest-numbered enabled pending source wins, and the pointer field has no effect.
- R10: Priority registers at 0x20 (normal) and 0x24 (fast) hold a rotate flag in bit 6 and a pointer in bits 5:0; with rotation on, the search starts at pointer+1 and wraps past 63, and reading the number register loads the winner into the pointer; with rotation off, such reads leave the pointer unchanged.
- R11: A level change shows in the status bit after the second rising clock edge following the input change, and an edge event shows after the third.
- R12: A byte access uses byte lane addr[1:0]: writes take wdata[7:0], and reads return the byte zero-extended in rdata[7:0]. A word access at an aligned address covers four bytes, little-endian (control byte 4k+i in bits 8i+7:8i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Asynchronous interrupt request lines |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_word_i | input | 1 | 1 for a word access, 0 for a byte access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| aux_o | output | 6 | Auxiliary destination outputs |

## Verification
The arbiter is driven with pending patterns built from level sources. The patterns include an empty set, a single request on source 63, the full set, and pairs placed on either side of the rotation pointer. These separate lowest-number selection, wrap-around past 63, a pointer that lands on the sole requester, and a pointer value that fixed mode must ignore. Edge sources are pulsed and sampled one cycle before and one cycle after the expected latch edge, so that a wrong synchroniser depth shows up. Writes of zero and of one to status bits, byte and word lanes, disabled sources and every class of destination code are each tried, so that clearing, routing and lane selection faults each give a distinct wrong value.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_IRQ_NUM = 8'h00;
  localparam logic [7:0] OFS_FIQ_NUM = 8'h04;
  localparam logic [7:0] OFS_IRQ_PRI = 8'h20;
  localparam logic [7:0] OFS_FIQ_PRI = 8'h24;

  // Control byte fields
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_RISE_BIT = 5;
  localparam int CTL_FALL_BIT = 6;
  localparam int DEST_CODES   = 8;
  localparam int AUX_N        = DEST_CODES - 2;

  typedef struct packed {
    logic       en;
    logic       rise;
    logic       fall;
    logic [2:0] dest;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [7:0] b);
    ctl_t c;
    c.en   = b[CTL_EN_BIT];
    c.rise = b[CTL_RISE_BIT];
    c.fall = b[CTL_FALL_BIT];
    c.dest = b[2:0];
    return c;
  endfunction

  // Which byte lanes a bus write touches
  function automatic logic [3:0] lane_mask(input logic word, input logic [1:0] lane);
    logic [3:0] m;
    m = word ? 4'hF : (4'h1 << lane);
    return m;
  endfunction

  // Write data spread to lanes: a byte access replicates wdata[7:0]
  function automatic logic [31:0] lane_data(input logic word, input logic [31:0] wd);
    return word ? wd : {4{wd[7:0]}};
  endfunction

endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr_i,
  output logic stat_o
);
  logic s1_q, s2_q, s3_q, lat_q;
  logic edge_mode, rise_evt, fall_evt, set_evt;

  assign edge_mode = rise_en | fall_en;
  assign rise_evt  = s2_q & ~s3_q;
  assign fall_evt  = ~s2_q & s3_q;
  assign set_evt   = (rise_en & rise_evt) | (fall_en & fall_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (!edge_mode)   lat_q <= 1'b0;
      else if (set_evt) lat_q <= 1'b1;
      else if (clr_i)   lat_q <= 1'b0;
    end
  end

  assign stat_o = edge_mode ? lat_q : s2_q;

  // R4: a qualified rising edge is held in the latch on the next cycle
  p_rise_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en && s2_q && !s3_q) |=> lat_q);
  // R4: a qualified falling edge is held in the latch on the next cycle
  p_fall_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_en && !s2_q && s3_q) |=> lat_q);
  // R5: without a clear the latched event persists
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && lat_q && !clr_i) |=> lat_q);
  // R5: a clear with no new event empties the latch
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr_i && !set_evt) |=> !lat_q);
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  logic                 cfg_wr_i,
  input  logic                 cfg_rot_i,
  input  logic [$clog2(N)-1:0] cfg_ptr_i,
  input  logic                 ack_i,
  output logic [$clog2(N)-1:0] num_o,
  output logic                 any_o,
  output logic                 rot_o,
  output logic [$clog2(N)-1:0] ptr_o
);
  localparam int IW = $clog2(N);

  // Circular first-set search beginning at start; MSB flags a hit
  function automatic logic [IW:0] pick(input logic [N-1:0] req, input logic [IW-1:0] start);
    logic [IW:0] res;
    int j;
    res = {1'b0, IW'(N - 1)};
    for (int i = 0; i < N; i++) begin
      j = (int'(start) + i) % N;
      if (!res[IW] && req[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  logic          rot_q;
  logic [IW-1:0] ptr_q, start;
  logic [IW:0]   hit;

  assign start = rot_q ? IW'((int'(ptr_q) + 1) % N) : '0;
  assign hit   = pick(req_i, start);
  assign any_o = hit[IW];
  assign num_o = hit[IW-1:0];
  assign rot_o = rot_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= 1'b0;
      ptr_q <= '0;
    end else if (cfg_wr_i) begin
      rot_q <= cfg_rot_i;
      ptr_q <= cfg_ptr_i;
    end else if (ack_i && rot_q && hit[IW]) begin
      ptr_q <= hit[IW-1:0];
    end
  end

  // R8: idle reports the top source number
  p_idle_num_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> (num_o == IW'(N - 1)));
  // R8: a reported winner is really pending
  p_winner_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |-> req_i[num_o]);
  // R9: in fixed mode nothing below the winner is pending
  p_fixed_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_q && req_i != '0) |-> ((req_i & ((N'(1) << num_o) - N'(1))) == '0));
  // R10: an acknowledged rotating pick becomes the new pointer
  p_ptr_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_i && ack_i && rot_q && req_i != '0) |=> (ptr_q == $past(num_o)));
  // R10: acknowledges in fixed mode leave the pointer alone
  p_ptr_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_i && !rot_q) |=> $stable(ptr_q));
endmodule

// File: rtl/vic_rotprio.sv
module vic_rotprio
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [7:0]         bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic               bus_word_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [5:0]         aux_o
);
  localparam int IW        = $clog2(NUM_SRC);
  localparam int STAT_W    = NUM_SRC / 32;
  localparam int CTL_WORDS = NUM_SRC / 4;

  logic [7:0]         ctl_q [NUM_SRC];
  ctl_t               ctl_d [NUM_SRC];
  logic [NUM_SRC-1:0] stat, clr, en_v, pend;
  logic [NUM_SRC-1:0] dsel [DEST_CODES];
  logic [DEST_CODES-1:0] route;
  logic [31:0]        stat_w [STAT_W];
  logic [3:0]         wmask;
  logic [31:0]        wd_word;
  logic               ctl_hit, stat_hit;
  logic               irq_cfg_wr, fiq_cfg_wr, irq_ack, fiq_ack;
  logic [IW-1:0]      irq_num, fiq_num, irq_ptr, fiq_ptr;
  logic               irq_any, fiq_any, irq_rot, fiq_rot;
  logic [31:0]        rd_word;

  // ---------------- bus write decode ----------------
  assign wmask      = lane_mask(bus_word_i, bus_addr_i[1:0]);
  assign wd_word    = lane_data(bus_word_i, bus_wdata_i);
  assign ctl_hit    = bus_wr_i && (bus_addr_i[7:6] == 2'b01);
  assign stat_hit   = bus_wr_i && (bus_addr_i[7:3] == 5'b10000);
  assign irq_cfg_wr = bus_wr_i && (bus_addr_i[7:2] == OFS_IRQ_PRI[7:2]) && wmask[0];
  assign fiq_cfg_wr = bus_wr_i && (bus_addr_i[7:2] == OFS_FIQ_PRI[7:2]) && wmask[0];
  assign irq_ack    = bus_rd_i && (bus_addr_i == OFS_IRQ_NUM);
  assign fiq_ack    = bus_rd_i && (bus_addr_i == OFS_FIQ_NUM);

  // ---------------- control bytes ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_SRC; n++) ctl_q[n] <= 8'h00;
    end else if (ctl_hit) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (bus_addr_i[5:2] == 4'(n / 4) && wmask[n % 4])
          ctl_q[n] <= wd_word[8*(n % 4) +: 8];
      end
    end
  end

  // ---------------- per-source cells ----------------
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign ctl_d[n] = ctl_decode(ctl_q[n]);
    assign en_v[n]  = ctl_d[n].en;
    assign clr[n]   = stat_hit && (bus_addr_i[2] == 1'(n / 32))
                      && wmask[(n % 32) / 8] && wd_word[n % 32];
    vic_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i[n]),
      .rise_en (ctl_d[n].rise),
      .fall_en (ctl_d[n].fall),
      .clr_i   (clr[n]),
      .stat_o  (stat[n])
    );
  end

  for (genvar w = 0; w < STAT_W; w++) begin : g_statw
    assign stat_w[w] = stat[32*w +: 32];
  end

  assign pend = stat & en_v;

  // ---------------- destination routing ----------------
  for (genvar d = 0; d < DEST_CODES; d++) begin : g_dest
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
      assign dsel[d][n] = (ctl_d[n].dest == 3'(d));
    end
    assign route[d] = |(pend & dsel[d]);
  end

  assign irq_o = route[0];
  assign fiq_o = route[1];
  assign aux_o = route[DEST_CODES-1:2];

  // ---------------- arbiters ----------------
  vic_prio_arb #(.N(NUM_SRC)) u_irq_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (pend & dsel[0]),
    .cfg_wr_i  (irq_cfg_wr),
    .cfg_rot_i (wd_word[6]),
    .cfg_ptr_i (wd_word[IW-1:0]),
    .ack_i     (irq_ack),
    .num_o     (irq_num),
    .any_o     (irq_any),
    .rot_o     (irq_rot),
    .ptr_o     (irq_ptr)
  );

  vic_prio_arb #(.N(NUM_SRC)) u_fiq_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (pend & dsel[1]),
    .cfg_wr_i  (fiq_cfg_wr),
    .cfg_rot_i (wd_word[6]),
    .cfg_ptr_i (wd_word[IW-1:0]),
    .ack_i     (fiq_ack),
    .num_o     (fiq_num),
    .any_o     (fiq_any),
    .rot_o     (fiq_rot),
    .ptr_o     (fiq_ptr)
  );

  // ---------------- read mux ----------------
  always_comb begin
    rd_word = '0;
    if (bus_addr_i[7:6] == 2'b01) begin
      for (int l = 0; l < 4; l++)
        rd_word[8*l +: 8] = ctl_q[{bus_addr_i[5:2], 2'(l)}];
    end else if (bus_addr_i[7:3] == 5'b10000) begin
      rd_word = stat_w[bus_addr_i[2]];
    end else begin
      case (bus_addr_i[7:2])
        OFS_IRQ_NUM[7:2]: rd_word = 32'(irq_num);
        OFS_FIQ_NUM[7:2]: rd_word = 32'(fiq_num);
        OFS_IRQ_PRI[7:2]: rd_word = 32'({irq_rot, irq_ptr});
        OFS_FIQ_PRI[7:2]: rd_word = 32'({fiq_rot, fiq_ptr});
        default:          rd_word = '0;
      endcase
    end
  end

  assign bus_rdata_o = bus_word_i ? rd_word
                                  : {24'h0, rd_word[{bus_addr_i[1:0], 3'b000} +: 8]};

  // R8: normal output low means the number register shows idle
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_num == IW'(NUM_SRC - 1)));
  // R8: the arbiters and the outputs agree on whether anything is pending
  p_any_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_any == irq_o) && (fiq_any == fiq_o));
  // R2: with no enabled pending source every output is quiet
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!irq_o && !fiq_o && aux_o == '0));
endmodule

// File: tb/tb_vic_rotprio.sv
module tb_vic_rotprio;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b1;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          irq, fiq;
  logic [5:0]    aux;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_rotprio dut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_word_i(bus_word), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .fiq_o(fiq), .aux_o(aux)
  );

  // {rotate, pointer[5:0], pending pattern[63:0], expected number[5:0]}
  localparam int TN = 10;
  localparam logic [76:0] TBL [TN] = '{
    {1'b0, 6'd0,  64'h0,                    6'd63},
    {1'b0, 6'd0,  64'h0000_0100_0000_0020,  6'd5},
    {1'b0, 6'd0,  64'h8000_0000_0000_0000,  6'd63},
    {1'b0, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF,  6'd0},
    {1'b1, 6'd5,  64'h0000_0100_0000_0020,  6'd40},
    {1'b1, 6'd40, 64'h0000_0100_0000_0020,  6'd5},
    {1'b1, 6'd63, 64'h8000_0000_0000_0001,  6'd0},
    {1'b1, 6'd62, 64'h8000_0000_0000_0000,  6'd63},
    {1'b1, 6'd10, 64'h0000_0000_0000_0400,  6'd10},
    {1'b0, 6'd10, 64'h0000_0100_0000_0020,  6'd5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic word, input logic [31:0] d);
    bus_addr = a; bus_word = word; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic word, output logic [31:0] d);
    bus_addr = a; bus_word = word; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fiq", {31'b0, fiq}, 0);
    chk("R1 aux", {26'b0, aux}, 0);
    rd(8'h00, 1, d); chk("R1 irq number idle", d, 63);
    rd(8'h04, 1, d); chk("R1 fiq number idle", d, 63);
    rd(8'h20, 1, d); chk("R1 irq priority", d, 0);
    rd(8'h7C, 1, d); chk("R1 control bytes", d, 0);

    // enable every source: level, normal output (R12 word writes)
    for (int k = 0; k < NS/4; k++) wr(8'(8'h40 + 4*k), 1, 32'h0808_0808);
    rd(8'h44, 1, d); chk("R12 word readback", d, 32'h0808_0808);

    // arbitration table (R8 R9 R10)
    for (int t = 0; t < TN; t++) begin
      wr(8'h20, 1, {25'b0, TBL[t][76], TBL[t][75:70]});
      src = TBL[t][69:6];
      waitc(2);
      chk($sformatf("R6 irq level vector %0d", t), {31'b0, irq}, {31'b0, (TBL[t][69:6] != 0)});
      rd(8'h00, 1, d);
      chk($sformatf("R9/R10 winner vector %0d", t), d, {26'b0, TBL[t][5:0]});
    end

    // R10 pointer advance on read in rotating mode
    src = '0;
    wr(8'h20, 1, 32'h40);
    src[7] = 1'b1; src[20] = 1'b1;
    waitc(2);
    rd(8'h00, 1, d); chk("R10 first rotate pick", d, 7);
    rd(8'h20, 1, d); chk("R10 pointer after read", d, 32'h47);
    rd(8'h00, 1, d); chk("R10 second rotate pick", d, 20);
    rd(8'h20, 1, d); chk("R10 pointer moved again", d, 32'h54);
    rd(8'h00, 1, d); chk("R10 wrap pick", d, 7);
    wr(8'h20, 1, 32'h05);
    rd(8'h00, 1, d); chk("R9 fixed pick ignores pointer", d, 7);
    rd(8'h20, 1, d); chk("R10 fixed read keeps pointer", d, 32'h05);
    wr(8'h20, 1, 32'h00);

    // R8 / R7 source 63 against idle
    src = '0; src[63] = 1'b1;
    waitc(2);
    rd(8'h00, 1, d); chk("R8 source 63 number", d, 63);
    rd(8'h84, 1, d); chk("R7 status word 1 bit31", d, 32'h8000_0000);
    rd(8'h87, 0, d); chk("R12 byte read status lane 3", d, 32'h80);
    src = '0;
    waitc(2);
    rd(8'h84, 1, d); chk("R8 idle status word 1", d, 0);
    chk("R8 irq idle", {31'b0, irq}, 0);

    // R4/R11 rising edge on source 3
    wr(8'h43, 0, 32'h28);
    src[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(8'h80, 1, d); chk("R11 edge not yet latched", d & 32'h8, 0);
    rd(8'h80, 1, d); chk("R11 edge latched third edge", d & 32'h8, 32'h8);
    chk("R4 irq from edge", {31'b0, irq}, 1);
    rd(8'h00, 1, d); chk("R9 edge source number", d, 3);
    src[3] = 1'b0;

    // R4 falling edge on source 4
    wr(8'h44, 0, 32'h48);
    src[4] = 1'b1;
    waitc(4);
    rd(8'h80, 1, d); chk("R4 rise ignored in falling mode", d & 32'h10, 0);
    src[4] = 1'b0;
    waitc(4);
    rd(8'h80, 1, d); chk("R4 falling latched, rising held", d & 32'hFF, 32'h18);

    // R5 clearing
    wr(8'h80, 0, 32'h00);
    rd(8'h80, 1, d); chk("R5 write zero keeps latches", d & 32'hFF, 32'h18);
    wr(8'h80, 1, 32'h08);
    rd(8'h80, 1, d); chk("R5 write one clears bit3 only", d & 32'hFF, 32'h10);
    wr(8'h80, 0, 32'h10);
    rd(8'h80, 1, d); chk("R5 byte clear bit4", d & 32'hFF, 0);
    chk("R5 irq after clear", {31'b0, irq}, 0);

    // R3/R5 level source 9 ignores writes and does not latch
    src[9] = 1'b1;
    waitc(2);
    wr(8'h81, 0, 32'h02);
    rd(8'h80, 1, d); chk("R5 level bit unaffected by write", d & 32'h200, 32'h200);
    rd(8'h00, 1, d); chk("R3 level source wins", d, 9);
    src[9] = 1'b0;
    waitc(2);
    rd(8'h80, 1, d); chk("R3 level bit follows input", d & 32'h200, 0);

    // R11 level latency on source 20
    src[20] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(8'h80, 1, d); chk("R11 level after one edge", d & 32'h10_0000, 0);
    rd(8'h80, 1, d); chk("R11 level after two edges", d & 32'h10_0000, 32'h10_0000);
    src[20] = 1'b0;

    // R6 destinations
    wr(8'h4A, 0, 32'h09);
    wr(8'h4B, 0, 32'h0A);
    wr(8'h4C, 0, 32'h0F);
    src[10] = 1'b1; src[11] = 1'b1; src[12] = 1'b1;
    waitc(2);
    chk("R6 fiq routed", {31'b0, fiq}, 1);
    chk("R6 irq not routed", {31'b0, irq}, 0);
    chk("R6 aux codes 2 and 7", {26'b0, aux}, 32'h21);
    rd(8'h04, 1, d); chk("R8 fiq number", d, 10);

    // R2 disable source 10
    wr(8'h4A, 0, 32'h01);
    chk("R2 disabled source drops fiq", {31'b0, fiq}, 0);
    rd(8'h04, 1, d); chk("R2 disabled not reported", d, 63);
    rd(8'h80, 1, d); chk("R2 status still visible", d & 32'h400, 32'h400);

    // R12 byte and word reads of control bytes
    rd(8'h4B, 0, d); chk("R12 byte read lane 3", d, 32'h0A);
    rd(8'h48, 1, d); chk("R12 word read little-endian", d, 32'h0A01_0808);

    src = '0;
    waitc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule